// File: doc/BRIEF.md
# Tagged Word Queue

This block is a synchronous first-in first-out queue of wide data words, each stored with a small side tag. The producer loads a tag register whenever it likes. Every later data write copies the tag register's current value into the entry together with the data. Because the tag is captured at write time, it leaves the queue in step with its word. Changing the tag register never alters words that are already queued.

The producer port offers three kinds of write. A blocking write is held off while the queue is full, and the producer retries it. A non-blocking write skips the full check: if the queue is full the word is discarded and a sticky overflow flag records the loss. A half-width write fills only the low half of the word and clears the upper half. The consumer sees the head entry directly on its outputs and removes it with a read strobe.

The block has no fixed direction. One instance carries traffic from the host to the user array, and a second instance, with its ports connected the other way round, carries traffic back. A flush input empties the queue and leaves the tag register as it is.

Top module: `tagq`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `level`=0), `tag_cur` is 0 and `overflow` is 0.
- R2: A pulse on `tag_we` loads `tag_in` into `tag_cur` at the clock edge. A data write stores the value `tag_cur` held before that edge, so a tag load in the same cycle applies only from the next write onward.
- R3: Entries leave in the order they were accepted, each with the tag it was stored with, whatever tag loads happen in between.
- R4: A blocking write (`wr_en`=1, `wr_nb`=0) while `full`=1 is not stored, leaves `level` unchanged and does not set `overflow`.
- R5: `rd_data`/`rd_tag` always show the head entry. A read (`rd_en`) while `empty`=1 has no effect.
- R6: A non-blocking write (`wr_nb`=1) is stored when the queue is not full. When the queue is full it is discarded and sets `overflow`. `overflow` stays set until an `ovf_clr` cycle that has no new overflow in it.
- R7: A half-width write (`wr_half`=1) stores `wr_data[DATA_W/2-1:0]` in the low half of the entry and zeros in the upper half.
- R8: `flush` empties the queue in one cycle and takes priority over a write or read in the same cycle. It does not change `tag_cur`.
- R9: A read and a write in the same cycle leave `level` unchanged when the queue is neither full nor empty. When full, only the read takes effect (`level`-1). When empty, only the write takes effect (`level`+1).
- R10: `full` is 1 exactly when `level`=DEPTH, `empty` is 1 exactly when `level`=0, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue; tag register kept |
| tag_we | input | 1 | Load the tag register |
| tag_in | input | TAG_W | New tag value |
| wr_en | input | 1 | Write strobe |
| wr_nb | input | 1 | Write is non-blocking (drop on full) |
| wr_half | input | 1 | Write only the low half; upper half zeroed |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Remove the head entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow | output | 1 | Sticky: a non-blocking write was dropped |
| tag_cur | output | TAG_W | Current tag register value |
| rd_data | output | DATA_W | Head entry data |
| rd_tag | output | TAG_W | Head entry tag |

## Verification
The bench builds the queue with DEPTH=4 and keeps the default 64-bit data and 4-bit tag widths. The small depth lets a few writes reach the full boundary. That brings held blocking writes, dropped non-blocking writes, and simultaneous read and write at both full and empty within a short run. The full data width is kept so the test can show that a half-width write clears the upper 32 bits.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
    localparam int DATA_W_DEF = 64;
    localparam int TAG_W_DEF  = 4;
    localparam int DEPTH_DEF  = 8;

    // outcome of one producer-side write attempt
    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_PUSH = 2'd1,
        WK_HELD = 2'd2,
        WK_DROP = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/tagq_store.sv
module tagq_store #(
    parameter int ENT_W = 68,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tagq_ptrs.sv
module tagq_ptrs #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    ptr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign level  = st_q.cnt;
    assign full   = (st_q.cnt == FULL_CNT);
    assign empty  = (st_q.cnt == '0);
endmodule

// File: rtl/tagq.sv
module tagq
    import tagq_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int TAG_W  = TAG_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int HALF_W = DATA_W / 2,
    localparam int ENT_W  = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tag_we,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              wr_en,
    input  logic              wr_nb,
    input  logic              wr_half,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     level,
    output logic              overflow,
    output logic [TAG_W-1:0]  tag_cur,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             ovf;
    } side_s;

    side_s    side_d, side_q;
    wr_kind_e wkind;
    logic     push, pop;
    logic [AW-1:0]     wp, rp;
    logic [DATA_W-1:0] wr_word;
    logic [ENT_W-1:0]  ent_in, ent_out;

    // classify the write attempt
    always_comb begin
        if (!wr_en || flush) wkind = WK_IDLE;
        else if (!full)      wkind = WK_PUSH;
        else if (wr_nb)      wkind = WK_DROP;
        else                 wkind = WK_HELD;
    end

    assign push = (wkind == WK_PUSH);
    assign pop  = rd_en && !empty && !flush;

    generate
        if (HALF_W > 0 && HALF_W < DATA_W) begin : g_half
            assign wr_word = wr_half ? {{(DATA_W-HALF_W){1'b0}}, wr_data[HALF_W-1:0]} : wr_data;
        end else begin : g_full
            assign wr_word = wr_data;
        end
    endgenerate

    assign ent_in = {side_q.tag, wr_word};

    always_comb begin
        side_d = side_q;
        if (tag_we)  side_d.tag = tag_in;
        if (ovf_clr) side_d.ovf = 1'b0;
        if (wkind == WK_DROP) side_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) side_q <= '0;
        else        side_q <= side_d;
    end

    tagq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wp),
        .rd_ptr (rp),
        .level  (level),
        .full   (full),
        .empty  (empty)
    );

    tagq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wp),
        .wdata (ent_in),
        .raddr (rp),
        .rdata (ent_out)
    );

    assign rd_data  = ent_out[DATA_W-1:0];
    assign rd_tag   = ent_out[ENT_W-1:DATA_W];
    assign tag_cur  = side_q.tag;
    assign overflow = side_q.ovf;
endmodule

// File: rtl/tagq_chk.sv
module tagq_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             tag_we,
    input logic             wr_en,
    input logic             wr_nb,
    input logic             rd_en,
    input logic             ovf_clr,
    input logic             full,
    input logic             empty,
    input logic [CW-1:0]    level,
    input logic             overflow,
    input logic [TAG_W-1:0] tag_cur
);
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty}));

    a_r4_held_write: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !wr_nb && !rd_en && !flush && !ovf_clr && !overflow)
        |=> (full && !overflow && level == $past(level)));

    a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && wr_nb && !flush) |=> overflow);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && level == '0));

    a_r8_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_we |=> $stable(tag_cur));

    a_r9_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty && !flush) |=> (level == $past(level)));

    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en && !flush) |=> empty);
endmodule

bind tagq tagq_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .tag_we   (tag_we),
    .wr_en    (wr_en),
    .wr_nb    (wr_nb),
    .rd_en    (rd_en),
    .ovf_clr  (ovf_clr),
    .full     (full),
    .empty    (empty),
    .level    (level),
    .overflow (overflow),
    .tag_cur  (tag_cur)
);

// File: tb/tb_tagq.sv
module tb_tagq;
    localparam int DW = 64;
    localparam int TW = 4;
    localparam int DP = 4;
    localparam int CW = $clog2(DP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, tag_we = 0, wr_en = 0, wr_nb = 0, wr_half = 0, rd_en = 0, ovf_clr = 0;
    logic [TW-1:0] tag_in = '0;
    logic [DW-1:0] wr_data = '0;
    logic full, empty, overflow;
    logic [CW-1:0] level;
    logic [TW-1:0] tag_cur, rd_tag;
    logic [DW-1:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tagq #(.DATA_W(DW), .TAG_W(TW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .tag_we(tag_we), .tag_in(tag_in),
        .wr_en(wr_en), .wr_nb(wr_nb), .wr_half(wr_half), .wr_data(wr_data),
        .rd_en(rd_en), .ovf_clr(ovf_clr), .full(full), .empty(empty), .level(level),
        .overflow(overflow), .tag_cur(tag_cur), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    typedef struct packed {
        logic          wr;
        logic          nb;
        logic          half;
        logic          rd;
        logic          tw;
        logic [3:0]    tag;
        logic [2:0]    exp_lvl;
    } vec_t;

    // wr nb half rd tw tag lvl
    localparam vec_t VECS [16] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h5,3'd0},  // load tag 5
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,3'd1},  // write, tag 5
        '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h9,3'd2},  // write w/ same-cycle tag load: old tag
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,3'd3},  // write, tag 9
        '{1'b1,1'b0,1'b0,1'b1,1'b0,4'h0,3'd3},  // read+write mid
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,3'd4},  // nb write not full: stored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,3'd4},  // blocking write held at full
        '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h3,3'd3},  // read+write at full
        '{1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,3'd4},  // half write, tag 3
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd3},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd2},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd0},  // read while empty
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'h0,3'd1},  // read+write at empty
        '{1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,3'd0}
    };

    logic [TW+DW-1:0] mq [$];
    logic [TW-1:0] tag_m = '0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model, sample just after the edge
    task automatic cyc(input bit w, input bit nb, input bit hf, input bit r, input bit tw,
                       input logic [TW-1:0] tg, input logic [DW-1:0] d, input bit fl, input bit oc);
        int sz;
        @(negedge clk);
        sz = mq.size();
        if (r && sz > 0 && !fl) begin
            chk(rd_data == mq[0][DW-1:0], "R3 head data", rd_data, mq[0][DW-1:0]);
            chk(rd_tag == mq[0][TW+DW-1:DW], "R2 head tag", DW'(rd_tag), DW'(mq[0][TW+DW-1:DW]));
        end
        wr_en = w; wr_nb = nb; wr_half = hf; rd_en = r; tag_we = tw; tag_in = tg;
        wr_data = d; flush = fl; ovf_clr = oc;
        if (fl) mq.delete();
        else begin
            if (r && sz > 0) void'(mq.pop_front());
            if (w && sz < DP) mq.push_back({tag_m, hf ? {32'h0, d[31:0]} : d});
        end
        if (tw) tag_m = tg;
        @(posedge clk);
        #1;
        wr_en = 0; wr_nb = 0; wr_half = 0; rd_en = 0; tag_we = 0; flush = 0; ovf_clr = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk(empty && !full && level == 0, "R1 empty after reset", DW'({empty, full, level}), DW'({1'b1, 1'b0, CW'(0)}));
        chk(tag_cur == 0 && !overflow, "R1 tag/overflow reset", DW'({tag_cur, overflow}), 0);

        // table walk: R2 R3 R4 R5 R7 R9 R10
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] d;
            d = {8'hA5, 24'(i), 32'h7777_0000 + 32'(i)};
            cyc(VECS[i].wr, VECS[i].nb, VECS[i].half, VECS[i].rd, VECS[i].tw, VECS[i].tag, d, 1'b0, 1'b0);
            chk(level == CW'(VECS[i].exp_lvl), "R9 level", DW'(level), DW'(VECS[i].exp_lvl));
            chk(full == (VECS[i].exp_lvl == 3'(DP)) && empty == (VECS[i].exp_lvl == 0),
                "R10 flags", DW'({full, empty}), DW'({VECS[i].exp_lvl == 3'(DP), VECS[i].exp_lvl == 0}));
            chk(!overflow, "R4 no overflow", DW'(overflow), 0);
        end

        // R6 overflow on non-blocking write at full
        for (int i = 0; i < DP; i++) cyc(1, 0, 0, 0, 0, 0, 64'hBEEF_0000 + 64'(i), 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 64'hDEAD, 0, 0);
        chk(overflow && level == CW'(DP), "R6 drop sets overflow", DW'({overflow, level}), DW'({1'b1, CW'(DP)}));
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(overflow, "R6 overflow sticky", DW'(overflow), 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk(!overflow, "R6 overflow cleared", DW'(overflow), 0);
        chk(rd_data == 64'hBEEF_0000, "R6 dropped word not stored", rd_data, 64'hBEEF_0000);

        // R8 flush with write in same cycle; tag unchanged
        cyc(0, 0, 0, 0, 1, 4'hC, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 64'h1, 1, 0);
        chk(empty && level == 0, "R8 flush empties", DW'(level), 0);
        chk(tag_cur == 4'hC, "R8 tag kept", DW'(tag_cur), 64'hC);

        // R7 half write upper bits zero, R2 tag C
        cyc(1, 0, 1, 0, 0, 0, 64'hFFFF_FFFF_1234_5678, 0, 0);
        chk(rd_data == 64'h0000_0000_1234_5678, "R7 half write", rd_data, 64'h1234_5678);
        chk(rd_tag == 4'hC, "R2 tag captured", DW'(rd_tag), 64'hC);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk(empty, "R5 drained", DW'(empty), 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule